// File: doc/BRIEF.md
# Line Performance Error Counter Bank

This block keeps a separate running tally of five kinds of line impairment reported by a framed line receiver: bipolar violations, code violations, loss-of-frame events, framing bit errors and CRC errors. Each kind arrives as a single-cycle pulse on its own input. The block does not detect these impairments. It only counts them.

At an update event, all five running tallies are copied at once into holding registers and the tallies restart from zero. The host reads the holding registers through a small register read port. A two-bit mode field picks the one source that may cause an update. The source can be a one-second tick made inside the block by dividing the reference clock, a software command written to a register, or a rising edge on an external pin that is not tied to the clock. Each update sets a sticky done flag, which is also driven onto an interrupt output. The host clears the flag by writing one to it.

Top module: `errcnt_bank`

## Requirements
- R1: After reset, every holding register reads 0, the done flag (status address 2, bit 0) and `upd_irq` are 0, and the mode register (address 0, bits 1:0) reads 0, which selects the timer.
- R2: Each event input increments only its own running tally. On an update, all five tallies are copied together into holding registers, which read at addresses 4 (bipolar violation), 5 (code violation), 6 (loss of frame), 7 (framing bit error) and 8 (CRC error). A holding register keeps its value between updates.
- R3: On an update, each running tally restarts in that same cycle. An event that arrives in the update cycle is not part of the latched value and counts as 1 toward the next interval.
- R4: Running tallies saturate. Bipolar violation, code violation and CRC tallies stop at 65535. Loss-of-frame and framing bit tallies stop at 255.
- R5: With mode 0 (timer), an update happens once every `TICK_DIV` clock cycles.
- R6: With mode 1 (software), writing a value with bit 0 set to address 1 causes an update in the cycle of that write.
- R7: With mode 2 (external), one rising edge on `ext_upd` causes exactly one update, however long the pin then stays high.
- R8: Update sources that are not selected are ignored. Mode 3 selects no source at all.
- R9: The done flag is set by every update and holds its value until the host writes a value with bit 0 set to address 2. Writing 0 there leaves the flag as it is. `upd_irq` always equals the flag.
- R10: The mode register can be written at address 0 and reads back its value. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bpv | input | 1 | Bipolar violation pulse |
| ev_cv | input | 1 | Code violation pulse |
| ev_lof | input | 1 | Loss-of-frame pulse |
| ev_fbe | input | 1 | Framing bit error pulse |
| ev_crc | input | 1 | CRC error pulse |
| ext_upd | input | 1 | External update request; the block synchronises it to `clk` |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 4 | Host read address |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| upd_irq | output | 1 | Sticky update-done flag |

## Verification
The assertions assume that each event input is a clean pulse sampled on `clk`, and that the host does not rewrite the mode register in the same cycle in which it checks for an idle mode. They also assume that `ext_upd` stays high longer than one synchronizer stage before it falls. The stimulus follows these limits. It drives every input at the falling clock edge and holds each external request high for several cycles. It changes the mode only through single-cycle register writes made while no other update source is being exercised.

// File: rtl/errcnt_pkg.sv
package errcnt_pkg;

    localparam int NUM_CNT = 5;
    localparam int REG_AW  = 4;
    localparam int REG_DW  = 16;
    localparam int WIDE_W  = 16;
    localparam int NARROW_W = 8;

    localparam logic [REG_AW-1:0] ADDR_MODE  = 4'd0;
    localparam logic [REG_AW-1:0] ADDR_CMD   = 4'd1;
    localparam logic [REG_AW-1:0] ADDR_STAT  = 4'd2;
    localparam logic [REG_AW-1:0] ADDR_HOLD0 = 4'd4;

    typedef enum logic [1:0] {
        SRC_TIMER = 2'd0,
        SRC_SW    = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_NONE  = 2'd3
    } upd_src_e;

    typedef struct packed {
        logic              en;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } host_wr_t;

    // Index order: 0 bpv, 1 cv, 2 lof, 3 fbe, 4 crc
    function automatic int cnt_width(input int idx);
        return (idx == 2 || idx == 3) ? NARROW_W : WIDE_W;
    endfunction

endpackage

// File: rtl/errcnt_tick.sv
module errcnt_tick #(
    parameter int DIV = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // R5
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/errcnt_edge_sync.sv
module errcnt_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [2:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[1:0], async_in};
    end

    assign rise = stg[1] & ~stg[2];

    // R7
    one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/errcnt_satcnt.sv
module errcnt_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] val
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)                       val <= '0;
        else if (clr)                  val <= inc ? W'(1) : '0;
        else if (inc && val != MAXV)   val <= val + 1'b1;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (val == MAXV && !clr) |=> val == MAXV);

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc) |=> val == '0);

endmodule

// File: rtl/errcnt_bank.sv
module errcnt_bank
    import errcnt_pkg::*;
#(
    parameter int TICK_DIV = 100_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_bpv,
    input  logic              ev_cv,
    input  logic              ev_lof,
    input  logic              ev_fbe,
    input  logic              ev_crc,
    input  logic              ext_upd,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    output logic              upd_irq
);
    host_wr_t          hw;
    upd_src_e          mode;
    logic              tick, ext_rise, sw_req, clr_done, upd, done;
    logic [NUM_CNT-1:0] ev;
    logic [REG_DW-1:0] live_ext [NUM_CNT];
    logic [REG_DW-1:0] hold     [NUM_CNT];

    assign hw = '{en: wr_en, addr: wr_addr, data: wr_data};
    assign ev = {ev_crc, ev_fbe, ev_lof, ev_cv, ev_bpv};

    errcnt_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));
    errcnt_edge_sync u_sync (.clk(clk), .rst(rst), .async_in(ext_upd), .rise(ext_rise));

    assign sw_req   = hw.en && hw.addr == ADDR_CMD  && hw.data[0];
    assign clr_done = hw.en && hw.addr == ADDR_STAT && hw.data[0];

    always_comb begin
        unique case (mode)
            SRC_TIMER: upd = tick;
            SRC_SW:    upd = sw_req;
            SRC_EXT:   upd = ext_rise;
            default:   upd = 1'b0;
        endcase
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        localparam int W = cnt_width(i);
        logic [W-1:0] v;
        errcnt_satcnt #(.W(W)) u_cnt (
            .clk(clk), .rst(rst), .inc(ev[i]), .clr(upd), .val(v));
        assign live_ext[i] = REG_DW'(v);

        always_ff @(posedge clk) begin
            if (rst)      hold[i] <= '0;
            else if (upd) hold[i] <= live_ext[i];
        end

        // R2
        hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
            !upd |=> $stable(hold[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= SRC_TIMER;
            done <= 1'b0;
        end else begin
            if (hw.en && hw.addr == ADDR_MODE) mode <= upd_src_e'(hw.data[1:0]);
            if (upd)           done <= 1'b1;
            else if (clr_done) done <= 1'b0;
        end
    end

    assign upd_irq = done;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_MODE) rd_data = REG_DW'(mode);
        if (rd_addr == ADDR_STAT) rd_data = REG_DW'(done);
        for (int i = 0; i < NUM_CNT; i++)
            if (rd_addr == ADDR_HOLD0 + REG_AW'(i)) rd_data = hold[i];
    end

    // R9
    upd_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> upd_irq);

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !clr_done) |=> done);

    // R8
    idle_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SRC_NONE && !done && !(hw.en && hw.addr == ADDR_MODE)) |=> !done);

endmodule

// File: tb/errcnt_bank_test.sv
module errcnt_bank_test;
    localparam int DIV = 40;

    logic clk = 1'b0, rst = 1'b1;
    logic ev_bpv = 0, ev_cv = 0, ev_lof = 0, ev_fbe = 0, ev_crc = 0, ext_upd = 0;
    logic wr_en = 0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    logic upd_irq;
    int total = 0, bad = 0, cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    errcnt_bank #(.TICK_DIV(DIV)) uut (
        .clk(clk), .rst(rst), .ev_bpv(ev_bpv), .ev_cv(ev_cv), .ev_lof(ev_lof),
        .ev_fbe(ev_fbe), .ev_crc(ev_crc), .ext_upd(ext_upd), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .upd_irq(upd_irq));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a; #1 v = int'(rd_data);
    endtask

    // mask bit order: 0 bpv,1 cv,2 lof,3 fbe,4 crc; n single-cycle pulses
    task automatic pulse(input logic [4:0] m, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); {ev_crc, ev_fbe, ev_lof, ev_cv, ev_bpv} = m;
            @(negedge clk); {ev_crc, ev_fbe, ev_lof, ev_cv, ev_bpv} = '0;
        end
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_upd = 1;
        repeat (4) @(negedge clk);
        ext_upd = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        for (int a = 4; a < 9; a++) begin rd(4'(a), v); chk("R1 hold", v, 0); end
        rd(4'd2, v); chk("R1 done", v, 0);
        chk("R1 irq", int'(upd_irq), 0);
        rd(4'd0, v); chk("R1 mode", v, 0);
        wr(4'd0, 16'd1);
        rd(4'd0, v); chk("R10 mode readback", v, 1);
        rd(4'd12, v); chk("R10 unmapped", v, 0);
    endtask

    task automatic t_counts();
        int v;
        wr(4'd1, 16'd1); wr(4'd2, 16'd1);
        pulse(5'b00001, 3); pulse(5'b00010, 5); pulse(5'b00100, 2);
        pulse(5'b01000, 7); pulse(5'b10000, 4); pulse(5'b00011, 2);
        wr(4'd1, 16'd1);
        rd(4'd4, v); chk("R2 bpv", v, 5);
        rd(4'd5, v); chk("R2 cv", v, 7);
        rd(4'd6, v); chk("R2 lof", v, 2);
        rd(4'd7, v); chk("R2 fbe", v, 7);
        rd(4'd8, v); chk("R6 crc", v, 4);
        chk("R9 irq set", int'(upd_irq), 1);
        wr(4'd2, 16'd0); rd(4'd2, v); chk("R9 write0 keeps", v, 1);
        wr(4'd2, 16'd1); rd(4'd2, v); chk("R9 cleared", v, 0);
        pulse(5'b00001, 2);
        rd(4'd4, v); chk("R2 hold stable", v, 5);
    endtask

    task automatic t_coincide();
        int v;
        wr(4'd1, 16'd1);
        pulse(5'b00010, 3);
        @(negedge clk); wr_en = 1; wr_addr = 4'd1; wr_data = 16'd1; ev_cv = 1;
        @(negedge clk); wr_en = 0; ev_cv = 0;
        rd(4'd5, v); chk("R3 latched", v, 3);
        wr(4'd1, 16'd1);
        rd(4'd5, v); chk("R3 carried", v, 1);
    endtask

    task automatic t_sat();
        int v;
        wr(4'd1, 16'd1);
        @(negedge clk); ev_bpv = 1; ev_lof = 1;
        repeat (65600) @(negedge clk);
        ev_bpv = 0; ev_lof = 0;
        wr(4'd1, 16'd1);
        rd(4'd4, v); chk("R4 bpv sat", v, 65535);
        rd(4'd6, v); chk("R4 lof sat", v, 255);
        rd(4'd5, v); chk("R4 cv untouched", v, 0);
    endtask

    task automatic t_ignore();
        int v;
        wr(4'd2, 16'd1);
        pulse(5'b10000, 6);
        ext_pulse();
        repeat (DIV + 5) @(negedge clk);
        chk("R8 sw mode ignores ext/timer", int'(upd_irq), 0);
        rd(4'd8, v); chk("R8 hold kept", v, 0);
        wr(4'd0, 16'd2);
        wr(4'd1, 16'd1);
        chk("R8 ext mode ignores sw", int'(upd_irq), 0);
        wr(4'd0, 16'd3);
        wr(4'd1, 16'd1); ext_pulse();
        repeat (DIV + 5) @(negedge clk);
        chk("R8 mode3 none", int'(upd_irq), 0);
    endtask

    task automatic t_ext();
        int v;
        wr(4'd0, 16'd2); wr(4'd2, 16'd1);
        ext_pulse();
        chk("R7 update", int'(upd_irq), 1);
        rd(4'd8, v); chk("R7 crc latched", v, 6);
        wr(4'd2, 16'd1);
        @(negedge clk); ext_upd = 1;
        repeat (20) @(negedge clk);
        chk("R7 one update", int'(upd_irq), 1);
        wr(4'd2, 16'd1);
        repeat (10) @(negedge clk);
        chk("R7 no second", int'(upd_irq), 0);
        ext_upd = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_timer();
        int v, c1, c2;
        wr(4'd0, 16'd0);
        c1 = 0; c2 = 0;
        for (int k = 0; k < 3 * DIV && c1 == 0; k++) begin
            @(negedge clk); if (upd_irq) c1 = cyc;
        end
        wr(4'd2, 16'd1);
        pulse(5'b00001, 5);
        for (int k = 0; k < 3 * DIV && c2 == 0; k++) begin
            @(negedge clk); if (upd_irq) c2 = cyc;
        end
        chk("R5 period", c2 - c1, DIV);
        rd(4'd4, v); chk("R5 bpv", v, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_counts();
        t_coincide();
        t_sat();
        t_ignore();
        t_ext();
        t_timer();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule